// File: doc/BRIEF.md
# Dual-Convention Multiplexed Host Bus Front End

This block connects an asynchronous 8-bit host bus, which carries both address and data on the same pins, to a small synchronous register file. A static convention pin selects how the host strobes are read. When it is high, the pins are an address strobe, a data strobe and a read/write direction line. When it is low (the default when the pin is left unconnected), the pins are an address-latch enable, an active-low read strobe and an active-low write strobe. The same physical pins serve both conventions.

Every host input, including the bus itself, passes through a two-stage synchronizer clocked by a faster system clock. Edges are found on the synchronized copies. The falling edge of the address strobe latches a 7-bit register address from bus bits 6..0. The trailing edge of a write access produces a one-cycle write pulse carrying the last data seen on the bus. The leading edge of a read access produces a one-cycle read pulse. The register file's read data is then driven back through a separate output plus an output-enable, which the pad ring uses to build the bidirectional bus. A chip select, active low, gates every access.

Top module: `muxbus_front`

## Requirements
- R1: After reset, `bus_oe`, `wr_pulse` and `rd_pulse` are 0, and `reg_addr` and `wr_data` are all zeros.
- R2: With `conv_ds`=1, a read access is `ds_rdn`=1 with `rw_wrn`=1, and a write access is `ds_rdn`=1 with `rw_wrn`=0. Holding `ds_rdn`=0 with `rw_wrn`=0 produces no pulse in this convention.
- R3: With `conv_ds`=0, a read access is `ds_rdn`=0 and a write access is `rw_wrn`=0, both active low.
- R4: On a falling edge of `as_ale` while selected, `reg_addr` takes bus bits 6..0 and ignores bit 7. It holds that value until the next such edge.
- R5: The trailing edge of a write access gives exactly one one-cycle `wr_pulse`. At that pulse, `wr_data` equals the bus value last seen while the write strobe was active.
- R6: The leading edge of a read access gives exactly one one-cycle `rd_pulse`. At that pulse, `reg_addr` holds the latched address.
- R7: While a read access is active, `bus_oe` is 1 and `bus_out` equals `rd_data`. `bus_oe` returns to 0 when `ds_rdn` falls (`conv_ds`=1) or when `ds_rdn` rises (`conv_ds`=0).
- R8: While `cs_n`=1, no address is latched, no pulse is produced and `bus_oe` stays 0.
- R9: A write followed by a read to the same address, in either convention, returns through `bus_out` the written value for all 128 addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the host strobes |
| rst | input | 1 | Synchronous active-high reset |
| conv_ds | input | 1 | Convention select: 1 = data strobe with direction line, 0 = separate read/write strobes |
| cs_n | input | 1 | Active-low chip select |
| as_ale | input | 1 | Address strobe; its falling edge latches the address |
| ds_rdn | input | 1 | Data strobe (conv_ds=1) or active-low read (conv_ds=0) |
| rw_wrn | input | 1 | Direction, 1 = read (conv_ds=1), or active-low write (conv_ds=0) |
| bus_in | input | 8 | Multiplexed address/data bus as seen at the pads |
| bus_out | output | 8 | Read data toward the pads |
| bus_oe | output | 1 | Pad output enable for `bus_out` |
| reg_addr | output | 7 | Latched register address |
| wr_data | output | 8 | Captured write data |
| wr_pulse | output | 1 | One-cycle register write enable |
| rd_pulse | output | 1 | One-cycle register read enable |
| rd_data | input | 8 | Read data from the register file at `reg_addr` |

## Verification
The hardest situation to reach from the ports is one where the pin levels would mean an access under the other convention but mean nothing under the selected one. For example, a low data strobe together with a low direction line is idle when `conv_ds`=1, but it reads as two active strobes when `conv_ds`=0. The bench drives exactly that pattern, and also complete cycles with chip select inactive. In each case it checks that no pulse appears, that `bus_oe` stays low and that the latched address is untouched. The main sweep writes and reads back all 128 addresses in both conventions, with bit 7 toggled during the address phase. A bench-side register file answers the read pulses.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic {
    CONV_SPLIT = 1'b0,
    CONV_DS    = 1'b1
  } conv_e;

  typedef struct packed {
    logic ale;
    logic rd;
    logic wr;
  } access_t;
endpackage

// File: rtl/muxbus_sync.sv
module muxbus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/muxbus_decode.sv
module muxbus_decode
  import muxbus_pkg::*;
(
  input  logic    conv_ds,
  input  logic    cs_n_s,
  input  logic    as_s,
  input  logic    ds_rdn_s,
  input  logic    rw_wrn_s,
  output access_t acc
);
  conv_e conv;
  logic  sel;

  always_comb begin
    conv = conv_e'(conv_ds);
    sel  = ~cs_n_s;
    acc.ale = sel & as_s;
    if (conv == CONV_DS) begin
      acc.rd = sel & ds_rdn_s & rw_wrn_s;
      acc.wr = sel & ds_rdn_s & ~rw_wrn_s;
    end else begin
      acc.rd = sel & ~ds_rdn_s;
      acc.wr = sel & ~rw_wrn_s;
    end
  end
endmodule

// File: rtl/muxbus_cycle.sv
module muxbus_cycle
  import muxbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int PRIME  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  access_t           acc,
  input  logic [DATA_W-1:0] bus_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_pulse,
  output logic              rd_pulse,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int CNT_W = $clog2(PRIME + 1);

  logic [CNT_W-1:0]  prime_cnt;
  logic              primed;
  access_t           acc_q;
  logic [DATA_W-1:0] wr_shadow;
  logic [DATA_W-1:0] out_q;
  logic              ale_fall, rd_rise, wr_fall;

  assign primed   = (prime_cnt == CNT_W'(PRIME));
  assign ale_fall = primed & acc_q.ale & ~acc.ale;
  assign rd_rise  = primed & acc.rd & ~acc_q.rd;
  assign wr_fall  = primed & acc_q.wr & ~acc.wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prime_cnt <= '0;
      acc_q     <= '0;
      wr_shadow <= '0;
      reg_addr  <= '0;
      wr_data   <= '0;
      wr_pulse  <= 1'b0;
      rd_pulse  <= 1'b0;
      bus_oe    <= 1'b0;
      out_q     <= '0;
    end else begin
      if (!primed) prime_cnt <= prime_cnt + 1'b1;
      acc_q    <= acc;
      if (acc.wr) wr_shadow <= bus_s;
      if (ale_fall) reg_addr <= bus_s[ADDR_W-1:0];
      if (wr_fall)  wr_data  <= wr_shadow;
      wr_pulse <= wr_fall;
      rd_pulse <= rd_rise;
      bus_oe   <= primed & acc.rd;
      out_q    <= rd_data;
    end
  end

  assign bus_out = bus_oe ? out_q : '0;

  // R5
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);

  // R6
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pulse |=> !rd_pulse);

  // R7
  rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pulse |-> bus_oe);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ale_fall) |-> $stable(reg_addr));

  // R8
  sel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc.wr && !acc_q.wr) |=> !wr_pulse);
endmodule

// File: rtl/muxbus_front.sv
module muxbus_front #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_ds,
  input  logic              cs_n,
  input  logic              as_ale,
  input  logic              ds_rdn,
  input  logic              rw_wrn,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_pulse,
  output logic              rd_pulse,
  input  logic [DATA_W-1:0] rd_data
);
  import muxbus_pkg::*;

  localparam int CTRL_W = 4;
  localparam int SYN_W  = CTRL_W + DATA_W;
  localparam int PRIME  = SYNC_STAGES + 1;

  logic [SYN_W-1:0]  raw_in, syn_out;
  logic [DATA_W-1:0] bus_s;
  access_t           acc;

  assign raw_in = {bus_in, cs_n, as_ale, ds_rdn, rw_wrn};
  assign bus_s  = syn_out[SYN_W-1:CTRL_W];

  muxbus_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .d_in  (raw_in),
    .d_out (syn_out)
  );

  muxbus_decode decode_i (
    .conv_ds  (conv_ds),
    .cs_n_s   (syn_out[3]),
    .as_s     (syn_out[2]),
    .ds_rdn_s (syn_out[1]),
    .rw_wrn_s (syn_out[0]),
    .acc      (acc)
  );

  muxbus_cycle #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRIME(PRIME)) cycle_i (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .bus_s    (bus_s),
    .rd_data  (rd_data),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .wr_pulse (wr_pulse),
    .rd_pulse (rd_pulse),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe)
  );
endmodule

// File: tb/muxbus_front_tb.sv
module muxbus_front_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_ds = 1'b0;
  logic       cs_n = 1'b1;
  logic       as_ale = 1'b0;
  logic       ds_rdn = 1'b1;
  logic       rw_wrn = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic [6:0] reg_addr;
  logic [7:0] wr_data;
  logic       wr_pulse, rd_pulse;
  logic [7:0] rd_data;

  logic [7:0] regs [128];
  int wr_cnt = 0, rd_cnt = 0;
  logic [6:0] last_wr_addr, last_rd_addr;
  logic [7:0] last_wr_data;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  muxbus_front dut_i (
    .clk(clk), .rst(rst), .conv_ds(conv_ds), .cs_n(cs_n), .as_ale(as_ale),
    .ds_rdn(ds_rdn), .rw_wrn(rw_wrn), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .reg_addr(reg_addr), .wr_data(wr_data),
    .wr_pulse(wr_pulse), .rd_pulse(rd_pulse), .rd_data(rd_data)
  );

  assign rd_data = regs[reg_addr];

  always @(posedge clk) begin
    if (!rst && wr_pulse) begin
      wr_cnt++;
      last_wr_addr = reg_addr;
      last_wr_data = wr_data;
      regs[reg_addr] = wr_data;
    end
    if (!rst && rd_pulse) begin
      rd_cnt++;
      last_rd_addr = reg_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input bit m);
    ds_rdn = m ? 1'b0 : 1'b1;
    rw_wrn = 1'b1;
  endtask

  task automatic addr_phase(input logic [7:0] a, input bit sel);
    @(negedge clk);
    cs_n = ~sel; bus_in = a; as_ale = 1'b1;
    repeat (3) @(negedge clk);
    as_ale = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input bit m, input logic [7:0] a, input logic [7:0] d, input bit sel);
    addr_phase(a, sel);
    bus_in = d;
    if (m) begin rw_wrn = 1'b0; @(negedge clk); ds_rdn = 1'b1; end
    else rw_wrn = 1'b0;
    repeat (4) @(negedge clk);
    if (m) begin ds_rdn = 1'b0; @(negedge clk); rw_wrn = 1'b1; end
    else rw_wrn = 1'b1;
    repeat (5) @(negedge clk);
    bus_in = 8'h00; cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input bit m, input logic [7:0] a, input bit sel,
                         output bit oe_mid, output logic [7:0] val, output bit oe_end);
    addr_phase(a, sel);
    bus_in = 8'hzz;
    if (m) ds_rdn = 1'b1; else ds_rdn = 1'b0;
    repeat (6) @(negedge clk);
    oe_mid = bus_oe; val = bus_out;
    if (m) ds_rdn = 1'b0; else ds_rdn = 1'b1;
    repeat (5) @(negedge clk);
    oe_end = bus_oe;
    bus_in = 8'h00; cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit oe_m, oe_e;
    logic [7:0] v;
    int w0, r0;
    for (int i = 0; i < 128; i++) regs[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(bus_oe == 0 && wr_pulse == 0 && rd_pulse == 0, "R1 controls", {bus_oe, wr_pulse, rd_pulse}, 0);
    chk(reg_addr == 0 && wr_data == 0, "R1 regs", {reg_addr, wr_data}, 0);
    repeat (5) @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      idle(m[0]);
      conv_ds = m[0];
      repeat (6) @(negedge clk);
      // R4 R5 write sweep, bit 7 toggled in address phase
      for (int a = 0; a < 128; a++) begin
        logic [7:0] d;
        d = 8'((a * 37 + m * 91 + 5) & 255);
        w0 = wr_cnt;
        do_write(m[0], {a[1] ^ a[0], 7'(a)}, d, 1'b1);
        chk(reg_addr == 7'(a), "R4 addr latch", reg_addr, a);
        chk(wr_cnt == w0 + 1, m ? "R2 write pulse count" : "R3 write pulse count", wr_cnt - w0, 1);
        chk(last_wr_data == d && last_wr_addr == 7'(a), "R5 write data", last_wr_data, d);
      end
      // R6 R7 R9 read sweep
      for (int a = 0; a < 128; a++) begin
        logic [7:0] d;
        d = 8'((a * 37 + m * 91 + 5) & 255);
        r0 = rd_cnt;
        do_read(m[0], {a[0], 7'(a)}, 1'b1, oe_m, v, oe_e);
        chk(rd_cnt == r0 + 1 && last_rd_addr == 7'(a), "R6 read pulse", rd_cnt - r0, 1);
        chk(oe_m == 1'b1, "R7 drive during read", oe_m, 1);
        chk(v == d, "R9 readback", v, d);
        chk(oe_e == 1'b0, "R7 release", oe_e, 0);
      end
      // R8 deselected write and read
      w0 = wr_cnt; r0 = rd_cnt;
      do_write(m[0], 8'h05, 8'hA5, 1'b0);
      chk(wr_cnt == w0, "R8 no write pulse", wr_cnt - w0, 0);
      chk(reg_addr == 7'd127, "R8 no addr latch", reg_addr, 127);
      do_read(m[0], 8'h05, 1'b0, oe_m, v, oe_e);
      chk(rd_cnt == r0 && oe_m == 0, "R8 no read drive", oe_m, 0);
      chk(regs[5] == 8'((5 * 37 + m * 91 + 5) & 255), "R8 register untouched", regs[5], (5 * 37 + m * 91 + 5) & 255);
    end

    // R2 pattern that is active only under the split convention
    conv_ds = 1'b1; idle(1'b1);
    repeat (6) @(negedge clk);
    w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk);
    cs_n = 1'b0; ds_rdn = 1'b0; rw_wrn = 1'b0;
    repeat (8) @(negedge clk);
    chk(bus_oe == 0, "R2 no drive on split pattern", bus_oe, 0);
    rw_wrn = 1'b1;
    repeat (6) @(negedge clk);
    chk(wr_cnt == w0 && rd_cnt == r0, "R2 no pulses on split pattern", wr_cnt + rd_cnt - w0 - r0, 0);
    cs_n = 1'b1;

    // R3 split convention: read held across several cycles gives one pulse
    conv_ds = 1'b0; idle(1'b0);
    repeat (6) @(negedge clk);
    r0 = rd_cnt;
    do_read(1'b0, 8'h11, 1'b1, oe_m, v, oe_e);
    chk(rd_cnt == r0 + 1 && v == regs[17], "R3 split read", v, regs[17]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule